// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar date in packed BCD: seconds, minutes, hours (24-hour), a weekday number, day of month, month and a two-digit year covering 2000 through 2099. A prescaler counts enable pulses from a slow time base. Once a full second of pulses has gone by, the counter chain advances by one second, and each carry ripples through the time and date fields. The date logic knows the length of every month and the leap-year rule for February.

Software reaches the fields through a byte-wide port. Three addresses are used: a control byte, a low window byte and a high window byte. A two-bit window pointer in the control byte picks which pair of fields the two window bytes show. Each access to the high byte steps the pointer down toward zero. This lets a burst of accesses walk from the year down to minutes and seconds. A write-unlock bit guards both the time fields and the run bit. Two read-only status bits report which half of the second is in progress and whether a second boundary is close.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset all fields are zero except these: weekday is 6, day is 01 and month is 01. The control byte reads 0x00: run off, unlocked off, sync off, half off, pointer 00.
- R2: While run is set, seconds advance by one after every TICKS_PER_SEC tick_in pulses. While run is clear, the prescaler is held at zero, half and sync read 0, and no field advances.
- R3: Seconds and minutes count 00..59 in BCD, with the low digit carrying at 9. Seconds going 59→00 adds one minute, and minutes going 59→00 adds one hour.
- R4: Hours count 00..23. Going 23→00 adds one day and one weekday. The weekday runs 0..6 and wraps 6→0 with no carry out.
- R5: The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends at 29 when the year is divisible by 4 and at 28 otherwise. After the last day, day returns to 01 and month advances.
- R6: Going from month 12 past its last day gives 01/01 and adds one to the year. The year wraps 99→00.
- R7: Control byte (address 0): bit7 run, bit6 unlock, bit5 sync, bit4 half, bits1:0 pointer. The low window (address 1) and high window (address 2) show, for pointer 00: seconds/minutes, 01: hours/weekday, 10: day/month, 11: year/0x00.
- R8: Any read or write of address 2 decrements the pointer by one, and the pointer stops at 00. Accesses to address 1 leave it unchanged.
- R9: While unlock is 0, window writes and writes of the run bit are ignored. The unlock bit and the pointer can always be written.
- R10: An accepted write of the seconds field (address 1, pointer 00) clears the prescaler, so half reads 0 and a full second must elapse before the next advance.
- R11: Sync reads 1 while run is set and the prescaler is in the last SYNC_TICKS counts of the second.
- R12: An accepted write lands on the clock edge of the bus write. It wins over an advance of the same field on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle time-base pulse |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (steps the pointer on address 2) |
| bus_addr | input | 2 | 0 control, 1 low window, 2 high window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |

## Verification
The bench builds the block with TICKS_PER_SEC = 8 and SYNC_TICKS = 2. A whole second then takes eight pulses, and the half and sync boundaries fall at counts 4 and 6, so each boundary can be hit exactly with a handful of pulses. With the short second, every carry case can be reached by loading a state just before the rollover and stepping one second. This covers month ends, the leap and non-leap Februaries, and the century wrap. The non-power-of-two prescaler variant is not built by the bench.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   typedef struct packed {
      logic [7:0] year;
      logic [7:0] month;
      logic [7:0] day;
      logic [7:0] wday;
      logic [7:0] hour;
      logic [7:0] minute;
      logic [7:0] sec;
   } rtc_time_t;

   typedef struct packed {
      logic year;
      logic month;
      logic day;
      logic wday;
      logic hour;
      logic minute;
      logic sec;
   } rtc_wr_t;

   typedef enum logic [1:0] {
      WIN_MINSEC = 2'b00,
      WIN_WDAYHR = 2'b01,
      WIN_MONDAY = 2'b10,
      WIN_YEAR   = 2'b11
   } win_sel_e;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_LO   = 2'd1;
   localparam logic [1:0] ADR_HI   = 2'd2;

   localparam int CTRL_RUN_BIT  = 7;
   localparam int CTRL_WREN_BIT = 6;

   localparam rtc_time_t RTC_RESET = '{year: 8'h00, month: 8'h01, day: 8'h01,
                                       wday: 8'h06, hour: 8'h00, minute: 8'h00,
                                       sec: 8'h00};

   // advance a packed BCD value, returning to first after last
   function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                           input logic [7:0] last,
                                           input logic [7:0] first);
      if (v == last)
         return first;
      else if (v[3:0] >= 4'd9)
         return {v[7:4] + 4'd1, 4'd0};
      else
         return v + 8'd1;
   endfunction

   // two-digit BCD year divisible by four: units + 2*tens is a multiple of 4
   function automatic logic is_leap(input logic [7:0] yr);
      logic [3:0] s;
      s = yr[3:0] + {2'b00, yr[4], 1'b0};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] mo,
                                             input logic [7:0] yr);
      case (mo)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcd_rtc_prescaler.sv
module bcd_rtc_prescaler #(
   parameter int TICKS_PER_SEC = 32768,
   parameter int SYNC_TICKS    = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic clear,
   output logic sec_step,
   output logic half_sec,
   output logic sync_win
);
   localparam int CW         = $clog2(TICKS_PER_SEC);
   localparam int SYNC_START = TICKS_PER_SEC - SYNC_TICKS;
   localparam bit IS_POW2    = (TICKS_PER_SEC & (TICKS_PER_SEC - 1)) == 0;

   initial begin
      assert (TICKS_PER_SEC >= 2 && (TICKS_PER_SEC % 2) == 0)
         else $error("TICKS_PER_SEC must be even and at least 2");
      assert (SYNC_TICKS >= 1 && SYNC_TICKS <= TICKS_PER_SEC / 2)
         else $error("SYNC_TICKS must lie in 1..TICKS_PER_SEC/2");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;
   logic          at_last;
   logic          hold;

   assign at_last  = (cnt == CW'(TICKS_PER_SEC - 1));
   assign hold     = clear | ~run;
   assign sec_step = run & tick & at_last & ~clear;
   assign sync_win = run & (cnt >= CW'(SYNC_START));

   generate
      if (IS_POW2) begin : g_pow2
         assign cnt_nxt  = cnt + 1'b1;
         assign half_sec = cnt[CW-1];
      end else begin : g_cmp
         localparam int HALF = TICKS_PER_SEC / 2;
         assign cnt_nxt  = at_last ? '0 : cnt + 1'b1;
         assign half_sec = (cnt >= CW'(HALF));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (hold)
         cnt <= '0;
      else if (tick)
         cnt <= cnt_nxt;
   end

   p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));
   p_wrap_after_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_step |=> (cnt == '0));
   p_clear_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !half_sec);
   p_sync_before_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sec_step |-> sync_win);

endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
   import bcd_rtc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      step,
   input  rtc_wr_t   wr,
   input  logic [7:0] wdata,
   output rtc_time_t tm
);
   logic       c_min, c_hr, c_day, c_mon, c_yr;
   logic [7:0] last_day;

   assign last_day = month_last(tm.month, tm.year);
   assign c_min    = step  && (tm.sec    == 8'h59);
   assign c_hr     = c_min && (tm.minute == 8'h59);
   assign c_day    = c_hr  && (tm.hour   == 8'h23);
   assign c_mon    = c_day && (tm.day    == last_day);
   assign c_yr     = c_mon && (tm.month  == 8'h12);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tm <= RTC_RESET;
      end else begin
         if (wr.sec)         tm.sec    <= wdata;
         else if (step)      tm.sec    <= bcd_step(tm.sec, 8'h59, 8'h00);
         if (wr.minute)      tm.minute <= wdata;
         else if (c_min)     tm.minute <= bcd_step(tm.minute, 8'h59, 8'h00);
         if (wr.hour)        tm.hour   <= wdata;
         else if (c_hr)      tm.hour   <= bcd_step(tm.hour, 8'h23, 8'h00);
         if (wr.wday)        tm.wday   <= wdata;
         else if (c_day)     tm.wday   <= bcd_step(tm.wday, 8'h06, 8'h00);
         if (wr.day)         tm.day    <= wdata;
         else if (c_day)     tm.day    <= bcd_step(tm.day, last_day, 8'h01);
         if (wr.month)       tm.month  <= wdata;
         else if (c_mon)     tm.month  <= bcd_step(tm.month, 8'h12, 8'h01);
         if (wr.year)        tm.year   <= wdata;
         else if (c_yr)      tm.year   <= bcd_step(tm.year, 8'h99, 8'h00);
      end
   end

   p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && tm.sec == 8'h59 && !wr.sec) |=> (tm.sec == 8'h00));
   p_min_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (c_hr && !wr.minute) |=> (tm.minute == 8'h00));
   p_wday_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (c_day && tm.wday == 8'h06 && !wr.wday) |=> (tm.wday == 8'h00));
   p_leap_feb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (c_day && tm.month == 8'h02 && tm.day == 8'h28 && is_leap(tm.year)
       && !wr.day && !wr.month) |=> (tm.day == 8'h29 && tm.month == 8'h02));
   p_year_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (c_yr && tm.year == 8'h99 && !wr.year) |=> (tm.year == 8'h00));
   p_sec_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr.sec |=> (tm.sec == $past(wdata)));

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
   import bcd_rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  rtc_time_t  tm,
   input  logic       half_sec,
   input  logic       sync_win,
   output logic       run,
   output logic       unlocked,
   output rtc_wr_t    fwr
);
   win_sel_e ptr;
   logic     ctrl_wr, hi_acc, lo_wr_ok, hi_wr_ok;

   assign ctrl_wr  = bus_wr && (bus_addr == ADR_CTRL);
   assign hi_acc   = (bus_wr || bus_rd) && (bus_addr == ADR_HI);
   assign lo_wr_ok = bus_wr && unlocked && (bus_addr == ADR_LO);
   assign hi_wr_ok = bus_wr && unlocked && (bus_addr == ADR_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= WIN_MINSEC;
         run      <= 1'b0;
         unlocked <= 1'b0;
      end else if (ctrl_wr) begin
         ptr      <= win_sel_e'(bus_wdata[1:0]);
         unlocked <= bus_wdata[CTRL_WREN_BIT];
         if (unlocked)
            run <= bus_wdata[CTRL_RUN_BIT];
      end else if (hi_acc && ptr != WIN_MINSEC) begin
         ptr <= win_sel_e'(ptr - 2'd1);
      end
   end

   always_comb begin
      fwr        = '0;
      fwr.sec    = lo_wr_ok && (ptr == WIN_MINSEC);
      fwr.minute = hi_wr_ok && (ptr == WIN_MINSEC);
      fwr.hour   = lo_wr_ok && (ptr == WIN_WDAYHR);
      fwr.wday   = hi_wr_ok && (ptr == WIN_WDAYHR);
      fwr.day    = lo_wr_ok && (ptr == WIN_MONDAY);
      fwr.month  = hi_wr_ok && (ptr == WIN_MONDAY);
      fwr.year   = lo_wr_ok && (ptr == WIN_YEAR);
   end

   always_comb begin
      bus_rdata = 8'h00;
      case (bus_addr)
         ADR_CTRL: bus_rdata = {run, unlocked, sync_win, half_sec, 2'b00, ptr};
         ADR_LO: begin
            case (ptr)
               WIN_MINSEC: bus_rdata = tm.sec;
               WIN_WDAYHR: bus_rdata = tm.hour;
               WIN_MONDAY: bus_rdata = tm.day;
               default:    bus_rdata = tm.year;
            endcase
         end
         ADR_HI: begin
            case (ptr)
               WIN_MINSEC: bus_rdata = tm.minute;
               WIN_WDAYHR: bus_rdata = tm.wday;
               WIN_MONDAY: bus_rdata = tm.month;
               default:    bus_rdata = 8'h00;
            endcase
         end
         default: bus_rdata = 8'h00;
      endcase
   end

   p_ptr_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_acc && ptr != WIN_MINSEC) |=> (ptr == win_sel_e'($past(ptr) - 2'd1)));
   p_ptr_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_acc && ptr == WIN_MINSEC) |=> (ptr == WIN_MINSEC));
   p_run_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !unlocked) |=> (run == $past(run)));
   p_one_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fwr));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import bcd_rtc_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int SYNC_TICKS    = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_in,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata
);
   rtc_time_t tm;
   rtc_wr_t   fwr;
   logic      run, unlocked, sec_step, half_sec, sync_win;

   bcd_rtc_prescaler #(
      .TICKS_PER_SEC (TICKS_PER_SEC),
      .SYNC_TICKS    (SYNC_TICKS)
   ) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (tick_in),
      .clear    (fwr.sec),
      .sec_step (sec_step),
      .half_sec (half_sec),
      .sync_win (sync_win)
   );

   bcd_rtc_calendar u_cal (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (sec_step),
      .wr    (fwr),
      .wdata (bus_wdata),
      .tm    (tm)
   );

   bcd_rtc_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tm        (tm),
      .half_sec  (half_sec),
      .sync_win  (sync_win),
      .run       (run),
      .unlocked  (unlocked),
      .fwr       (fwr)
   );

   p_locked_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !unlocked && bus_addr == ADR_HI && tm.sec != 8'h59)
      |=> $stable(tm.minute));
   p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && fwr == '0) |=> $stable(tm));

endmodule

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
   localparam int TPS = 8;
   localparam int SYN = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_in = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;
   bit  b_run    = 1'b0;
   bit  b_wren   = 1'b0;

   always #10 clk = ~clk;

   bcd_rtc_core #(.TICKS_PER_SEC(TPS), .SYNC_TICKS(SYN)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_strobe(input logic [1:0] a);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic ctrl(input logic [1:0] p);
      wr(2'd0, {b_run, b_wren, 4'b0000, p});
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_in = 1'b1;
      end
      @(negedge clk);
      tick_in = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] yr, mo, dy, wd, hr, mi, se);
      ctrl(2'b11);
      wr(2'd1, yr); wr(2'd2, 8'h00);
      wr(2'd1, dy); wr(2'd2, mo);
      wr(2'd1, hr); wr(2'd2, wd);
      wr(2'd1, se); wr(2'd2, mi);
   endtask

   task automatic check_time(input string tag, input logic [7:0] yr, mo, dy, wd, hr, mi, se);
      logic [7:0] v_yr, v_mo, v_dy, v_wd, v_hr, v_mi, v_se;
      ctrl(2'b11); peek(2'd1, v_yr);
      ctrl(2'b10); peek(2'd1, v_dy); peek(2'd2, v_mo);
      ctrl(2'b01); peek(2'd1, v_hr); peek(2'd2, v_wd);
      ctrl(2'b00); peek(2'd1, v_se); peek(2'd2, v_mi);
      check(tag, {8'h0, v_yr, v_mo, v_dy, v_wd, v_hr, v_mi, v_se},
                 {8'h0, yr, mo, dy, wd, hr, mi, se});
   endtask

   task automatic t_reset();
      logic [7:0] v;
      peek(2'd0, v);
      check("R1 control after reset", v, 8'h00);
      check_time("R1 fields after reset", 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
      ctrl(2'b11); peek(2'd2, v);
      check("R7 reserved high byte", v, 8'h00);
      ctrl(2'b00);
   endtask

   task automatic t_lock();
      logic [7:0] v;
      wr(2'd0, 8'h80);
      peek(2'd0, v);
      check("R9 run bit ignored while locked", v, 8'h00);
      wr(2'd1, 8'h33); wr(2'd2, 8'h44);
      check_time("R9 window writes ignored", 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
      b_wren = 1'b1; ctrl(2'b00);
      b_run = 1'b1; ctrl(2'b00);
      peek(2'd0, v);
      check("R9 run accepted when unlocked", v, 8'hC0);
      wr(2'd1, 8'h33);
      peek(2'd1, v);
      check("R9 seconds write accepted", v, 8'h33);
   endtask

   task automatic t_prescale();
      logic [7:0] v;
      wr(2'd1, 8'h00);
      ticks(3); peek(2'd0, v);
      check("R2 first half of second", v, 8'hC0);
      ticks(1); peek(2'd0, v);
      check("R2 second half flag", v, 8'hD0);
      ticks(2); peek(2'd0, v);
      check("R11 sync window open", v, 8'hF0);
      ticks(2); peek(2'd0, v);
      check("R2 R11 flags after step", v, 8'hC0);
      peek(2'd1, v);
      check("R2 one second after eight pulses", v, 8'h01);
      b_run = 1'b0; ctrl(2'b00);
      ticks(12); peek(2'd1, v);
      check("R2 no advance while stopped", v, 8'h01);
      peek(2'd0, v);
      check("R2 flags low while stopped", v, 8'h40);
      b_run = 1'b1; ctrl(2'b00);
   endtask

   task automatic t_resync();
      logic [7:0] v;
      wr(2'd1, 8'h00);
      ticks(5); peek(2'd0, v);
      check("R10 half set before resync", v, 8'hD0);
      wr(2'd1, 8'h10); peek(2'd0, v);
      check("R10 half cleared by seconds write", v, 8'hC0);
      ticks(7); peek(2'd1, v);
      check("R10 full second needed after resync", v, 8'h10);
      ticks(1); peek(2'd1, v);
      check("R10 step after full second", v, 8'h11);
   endtask

   task automatic t_carry();
      set_time(8'h05, 8'h06, 8'h10, 8'h02, 8'h07, 8'h09, 8'h59);
      ticks(TPS);
      check_time("R3 seconds carry into minute digit", 8'h05, 8'h06, 8'h10, 8'h02, 8'h07, 8'h10, 8'h00);
      set_time(8'h05, 8'h06, 8'h10, 8'h02, 8'h05, 8'h59, 8'h59);
      ticks(TPS);
      check_time("R3 minute carry into hour", 8'h05, 8'h06, 8'h10, 8'h02, 8'h06, 8'h00, 8'h00);
      set_time(8'h05, 8'h06, 8'h10, 8'h02, 8'h09, 8'h59, 8'h59);
      ticks(TPS);
      check_time("R3 hour digit carry", 8'h05, 8'h06, 8'h10, 8'h02, 8'h10, 8'h00, 8'h00);
   endtask

   task automatic t_day();
      set_time(8'h21, 8'h03, 8'h15, 8'h06, 8'h23, 8'h59, 8'h59);
      ticks(TPS);
      check_time("R4 midnight and weekday wrap", 8'h21, 8'h03, 8'h16, 8'h00, 8'h00, 8'h00, 8'h00);
      set_time(8'h21, 8'h03, 8'h19, 8'h03, 8'h23, 8'h59, 8'h59);
      ticks(TPS);
      check_time("R4 day digit carry and weekday", 8'h21, 8'h03, 8'h20, 8'h04, 8'h00, 8'h00, 8'h00);
   endtask

   task automatic month_end(input string tag, input logic [7:0] yr, mo, dy,
                            input logic [7:0] emo, edy);
      set_time(yr, mo, dy, 8'h01, 8'h23, 8'h59, 8'h59);
      ticks(TPS);
      check_time(tag, yr, emo, edy, 8'h02, 8'h00, 8'h00, 8'h00);
   endtask

   task automatic t_months();
      month_end("R5 April ends at 30",    8'h21, 8'h04, 8'h30, 8'h05, 8'h01);
      month_end("R5 November ends at 30", 8'h21, 8'h11, 8'h30, 8'h12, 8'h01);
      month_end("R5 January has 31",      8'h21, 8'h01, 8'h30, 8'h01, 8'h31);
      month_end("R5 January ends at 31",  8'h21, 8'h01, 8'h31, 8'h02, 8'h01);
      month_end("R5 Feb 28 common year",  8'h23, 8'h02, 8'h28, 8'h03, 8'h01);
      month_end("R5 Feb 28 leap year 24", 8'h24, 8'h02, 8'h28, 8'h02, 8'h29);
      month_end("R5 Feb 29 leap year 24", 8'h24, 8'h02, 8'h29, 8'h03, 8'h01);
      month_end("R5 year 00 is leap",     8'h00, 8'h02, 8'h28, 8'h02, 8'h29);
      month_end("R5 year 10 is common",   8'h10, 8'h02, 8'h28, 8'h03, 8'h01);
      month_end("R5 year 12 is leap",     8'h12, 8'h02, 8'h28, 8'h02, 8'h29);
   endtask

   task automatic t_year();
      set_time(8'h45, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
      ticks(TPS);
      check_time("R6 new year carry", 8'h46, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
      set_time(8'h99, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
      ticks(TPS);
      check_time("R6 year wraps 99 to 00", 8'h00, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00);
      set_time(8'h39, 8'h12, 8'h31, 8'h04, 8'h23, 8'h59, 8'h59);
      ticks(TPS);
      check_time("R6 year tens digit carry", 8'h40, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00);
   endtask

   task automatic t_pointer();
      logic [7:0] v;
      set_time(8'h07, 8'h08, 8'h09, 8'h03, 8'h11, 8'h22, 8'h33);
      ctrl(2'b11); peek(2'd1, v);
      check("R7 pointer 11 low is year", v, 8'h07);
      rd_strobe(2'd1); peek(2'd0, v);
      check("R8 low read keeps pointer", v, 8'hC3);
      rd_strobe(2'd2); peek(2'd0, v);
      check("R8 high read steps to 10", v, 8'hC2);
      peek(2'd2, v);
      check("R7 pointer 10 high is month", v, 8'h08);
      rd_strobe(2'd2); peek(2'd2, v);
      check("R7 pointer 01 high is weekday", v, 8'h03);
      peek(2'd1, v);
      check("R7 pointer 01 low is hours", v, 8'h11);
      rd_strobe(2'd2); rd_strobe(2'd2); peek(2'd0, v);
      check("R8 pointer stops at 00", v, 8'hC0);
      peek(2'd2, v);
      check("R7 pointer 00 high is minutes", v, 8'h22);
   endtask

   task automatic t_priority();
      logic [7:0] v;
      set_time(8'h07, 8'h08, 8'h09, 8'h03, 8'h11, 8'h20, 8'h59);
      ticks(TPS - 1);
      @(negedge clk);
      tick_in = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h42;
      @(negedge clk);
      tick_in = 1'b0; bus_wr = 1'b0;
      check_time("R12 minute write beats carry", 8'h07, 8'h08, 8'h09, 8'h03, 8'h11, 8'h42, 8'h00);
      wr(2'd1, 8'h10);
      ticks(TPS - 1);
      @(negedge clk);
      tick_in = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h33;
      @(negedge clk);
      tick_in = 1'b0; bus_wr = 1'b0;
      peek(2'd1, v);
      check("R12 seconds write beats step", v, 8'h33);
      ticks(TPS); peek(2'd1, v);
      check("R12 counting resumes from written value", v, 8'h34);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lock();
      t_prescale();
      t_resync();
      t_carry();
      t_day();
      t_months();
      t_year();
      t_pointer();
      t_priority();
      finish_run();
   end

endmodule